// File: doc/BRIEF.md
# AC-link Output Frame Serializer

This block is the controller-side transmitter of an AC'97-style codec link. It runs from the bit clock that the codec supplies. It produces a frame marker (`sync_o`) and a serial data line (`sdata_o`). Every frame is 256 bit times long: a 16-bit tag slot followed by twelve 20-bit slots. The tag says which of the following slots carry real content. Slot 1 carries a register command word. Slot 2 carries write data. Slots 3 and 4 carry the left and right playback samples. Every other bit position in the frame is sent as zero.

Software-side logic hands over one register command and one stereo sample pair through two independent valid/ready channels. Each accepted item waits in a one-deep pending register. At the next frame boundary it moves into an on-air register, which stays stable for the whole frame while the bits are shifted out MSB first. The ready output of a channel stays low from acceptance until the boundary that loads the item. As a result, each frame carries at most one command and one sample pair.

Top module: `aclo_frame_tx`

## Requirements
- R1: A frame lasts exactly 256 bit times. `sync_o` is high for the first 16 bit times of each frame and low for the other 240, so each frame starts with exactly one low-to-high transition of `sync_o`.
- R2: Both outputs change only on the rising edge of `clk_i`. In the bit time after `sync_o` rises, `sdata_o` carries frame bit 0 (tag bit 15). Frame bit b appears b+1 bit times after the rise of `sync_o`, with each slot sent MSB first.
- R3: Tag bits, sent from bit 15 down to bit 0:
  - bit 15 is set when slot 1, 2, 3 or 4 carries content;
  - bit 14 is set when a command is on air;
  - bit 13 is set when the on-air command is a write;
  - bits 12 and 11 are set when a sample pair is on air;
  - bits 10 to 0 are zero.
- R4: Slot 1 of a frame carrying a command holds the command word:
  - bit 19 is the operation flag (1 = read, 0 = write);
  - bits 18 to 12 are the 7-bit register address;
  - bits 11 to 0 are zero.

  Slot 1 is all zero when no command is on air.
- R5: Slot 2 holds the 16-bit write data in bits 19 to 4, with bits 3 to 0 zero. Slot 2 is all zero for a read command and when no command is on air.
- R6: Slots 3 and 4 hold the left and right samples. Each sample is `SAMPLE_W` bits wide, placed in bits 19 down to 20-`SAMPLE_W`, with the low bits below it zero. Both slots are zero when no sample pair is on air.
- R7: Slots 5 through 12 are always all zero.
- R8: A channel's ready output is high when nothing is pending on that channel. An item is accepted on a rising edge where valid and ready are both high. Ready is then low in the next bit time and stays low until the frame boundary that loads the item. Valid and data presented while ready is low have no effect on any frame.
- R9: An item accepted before the boundary edge of a frame is sent in the next frame only. An item accepted on the boundary edge itself (the edge at which `sync_o` rises) is sent one frame later. The frame in between carries no trace of that item, and that channel's ready output stays low during that frame.
- R10: While `rst_n_i` is low, `sync_o` and `sdata_o` are low and both ready outputs are high. The first frame starts at the first rising edge after reset is released and carries no content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock from the codec |
| rst_n_i | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Command channel can accept |
| cmd_read_i | input | 1 | 1 = register read, 0 = register write |
| cmd_addr_i | input | 7 | Register address |
| cmd_wdata_i | input | 16 | Register write data |
| pcm_valid_i | input | 1 | Sample pair offered |
| pcm_ready_o | output | 1 | Sample channel can accept |
| pcm_left_i | input | SAMPLE_W | Left playback sample |
| pcm_right_i | input | SAMPLE_W | Right playback sample |
| sync_o | output | 1 | Frame marker |
| sdata_o | output | 1 | Serial frame data |

## Verification
Two functions can fall on the same rising edge:
- acceptance of a new item into the pending register;
- the frame-boundary load that moves pending items on air.

The bench provokes the overlap by raising valid in the last bit time of a frame, so that acceptance happens on the edge at which `sync_o` rises. It then judges two things:
- the frame that starts there is empty, and that channel's ready output stays low through it;
- the item appears complete in the following frame.

The same offer made one bit time earlier must land in the very next frame. This pins the boundary to a single edge.

// File: rtl/aclo_pkg.sv
package aclo_pkg;

   localparam int TAG_W      = 16;
   localparam int SLOT_W     = 20;
   localparam int DATA_SLOTS = 12;
   localparam int NUM_WORDS  = DATA_SLOTS + 1;
   localparam int FRAME_LEN  = TAG_W + DATA_SLOTS * SLOT_W;
   localparam int ADDR_W     = 7;
   localparam int CDATA_W    = 16;
   localparam int CMD_W      = 1 + ADDR_W + CDATA_W;
   localparam int SLOT_IW    = $clog2(NUM_WORDS);
   localparam int BIT_IW     = $clog2(SLOT_W);

   // slot order on the wire (the receiver decodes by position)
   localparam int S_TAG   = 0;
   localparam int S_CMDA  = 1;
   localparam int S_CMDD  = 2;
   localparam int S_LEFT  = 3;
   localparam int S_RIGHT = 4;

   // tag bit positions
   localparam int TAG_FRAME = 15;
   localparam int TAG_CMDA  = 14;
   localparam int TAG_CMDD  = 13;
   localparam int TAG_LEFT  = 12;
   localparam int TAG_RIGHT = 11;

   typedef struct packed {
      logic                 rd;
      logic [ADDR_W-1:0]    addr;
      logic [CDATA_W-1:0]   data;
   } cmd_t;

endpackage

// File: rtl/aclo_bit_timer.sv
module aclo_bit_timer
   import aclo_pkg::*;
(
   input  logic               clk_i,
   input  logic               rst_n_i,
   output logic [SLOT_IW-1:0] slot_o,
   output logic [BIT_IW-1:0]  bit_o,
   output logic               last_o,
   output logic               sync_win_o
);

   localparam logic [SLOT_IW-1:0] LAST_SLOT = SLOT_IW'(NUM_WORDS - 1);
   localparam logic [BIT_IW-1:0]  TAG_TOP   = BIT_IW'(TAG_W - 1);
   localparam logic [BIT_IW-1:0]  SLOT_TOP  = BIT_IW'(SLOT_W - 1);

   // reset parks the counters on the final frame bit, so the first edge
   // out of reset is a frame boundary
   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         slot_o <= LAST_SLOT;
         bit_o  <= '0;
      end else if (bit_o == '0) begin
         if (slot_o == LAST_SLOT) begin
            slot_o <= '0;
            bit_o  <= TAG_TOP;
         end else begin
            slot_o <= slot_o + 1'b1;
            bit_o  <= SLOT_TOP;
         end
      end else begin
         bit_o <= bit_o - 1'b1;
      end
   end

   assign last_o = (slot_o == LAST_SLOT) && (bit_o == '0);

   // marker is high for the bit time before tag bit 15 and the 15 tag bit
   // times after it (output register adds one bit time)
   assign sync_win_o = last_o || ((slot_o == '0) && (bit_o != '0));

   p_slot_range_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      slot_o <= LAST_SLOT);

   p_tag_bits_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (slot_o == '0) |-> (bit_o <= TAG_TOP));

   p_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      last_o |=> ((slot_o == '0) && (bit_o == TAG_TOP)));

   p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (bit_o != '0) |=> ((bit_o == $past(bit_o) - 1'b1) && $stable(slot_o)));

endmodule

// File: rtl/aclo_req_stage.sv
module aclo_req_stage #(
   parameter int W = 8
) (
   input  logic         clk_i,
   input  logic         rst_n_i,
   input  logic         valid_i,
   input  logic [W-1:0] data_i,
   output logic         ready_o,
   input  logic         load_i,
   output logic         air_vld_o,
   output logic [W-1:0] air_data_o
);

   if (W < 1) begin : g_bad_w
      $error("aclo_req_stage: W must be positive");
   end

   logic         pend_vld;
   logic [W-1:0] pend_data;

   assign ready_o = !pend_vld;

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         pend_vld   <= 1'b0;
         pend_data  <= '0;
         air_vld_o  <= 1'b0;
         air_data_o <= '0;
      end else begin
         if (load_i) begin
            air_vld_o  <= pend_vld;
            air_data_o <= pend_vld ? pend_data : '0;
            pend_vld   <= 1'b0;
         end
         // acceptance on a boundary edge lands in pending, not on air
         if (valid_i && !pend_vld) begin
            pend_vld  <= 1'b1;
            pend_data <= data_i;
         end
      end
   end

   p_ready_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (valid_i && ready_o) |=> !ready_o);

   p_pend_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (!ready_o && !load_i) |=> (!ready_o && $stable(pend_data)));

   p_air_load_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (load_i && !ready_o) |=> (air_vld_o && ready_o == !$past(valid_i && ready_o)));

   p_air_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !load_i |=> ($stable(air_vld_o) && $stable(air_data_o)));

endmodule

// File: rtl/aclo_slot_pack.sv
module aclo_slot_pack
   import aclo_pkg::*;
#(
   parameter int SAMPLE_W = 20
) (
   input  logic                                cmd_vld_i,
   input  cmd_t                                cmd_i,
   input  logic                                pcm_vld_i,
   input  logic [SAMPLE_W-1:0]                 left_i,
   input  logic [SAMPLE_W-1:0]                 right_i,
   output logic [NUM_WORDS-1:0][SLOT_W-1:0]    words_o
);

   localparam int PAD_W = SLOT_W - SAMPLE_W;

   logic [TAG_W-1:0]              tag;
   logic [1:0][SAMPLE_W-1:0]      smp;
   logic [1:0][SLOT_W-1:0]        just;

   always_comb begin
      tag            = '0;
      tag[TAG_CMDA]  = cmd_vld_i;
      tag[TAG_CMDD]  = cmd_vld_i && !cmd_i.rd;
      tag[TAG_LEFT]  = pcm_vld_i;
      tag[TAG_RIGHT] = pcm_vld_i;
      tag[TAG_FRAME] = cmd_vld_i || pcm_vld_i;
   end

   assign words_o[S_TAG]  = {{(SLOT_W - TAG_W){1'b0}}, tag};
   assign words_o[S_CMDA] = cmd_vld_i ?
                            {cmd_i.rd, cmd_i.addr, {(SLOT_W - 1 - ADDR_W){1'b0}}} : '0;
   assign words_o[S_CMDD] = (cmd_vld_i && !cmd_i.rd) ?
                            {cmd_i.data, {(SLOT_W - CDATA_W){1'b0}}} : '0;

   assign smp[0] = left_i;
   assign smp[1] = right_i;

   for (genvar ch = 0; ch < 2; ch++) begin : g_chan
      if (PAD_W == 0) begin : g_full
         assign just[ch] = smp[ch];
      end else begin : g_pad
         assign just[ch] = {smp[ch], {PAD_W{1'b0}}};
      end
      assign words_o[S_LEFT + ch] = pcm_vld_i ? just[ch] : '0;
   end

   for (genvar s = S_RIGHT + 1; s < NUM_WORDS; s++) begin : g_rsvd
      assign words_o[s] = '0;
   end

endmodule

// File: rtl/aclo_frame_tx.sv
module aclo_frame_tx
   import aclo_pkg::*;
#(
   parameter int SAMPLE_W = 20
) (
   input  logic                clk_i,
   input  logic                rst_n_i,
   input  logic                cmd_valid_i,
   output logic                cmd_ready_o,
   input  logic                cmd_read_i,
   input  logic [ADDR_W-1:0]   cmd_addr_i,
   input  logic [CDATA_W-1:0]  cmd_wdata_i,
   input  logic                pcm_valid_i,
   output logic                pcm_ready_o,
   input  logic [SAMPLE_W-1:0] pcm_left_i,
   input  logic [SAMPLE_W-1:0] pcm_right_i,
   output logic                sync_o,
   output logic                sdata_o
);

   if (SAMPLE_W < 1 || SAMPLE_W > SLOT_W) begin : g_bad_sample
      $error("aclo_frame_tx: SAMPLE_W must lie in 1..SLOT_W");
   end
   if (TAG_W > SLOT_W || 1 + ADDR_W > SLOT_W || CDATA_W > SLOT_W) begin : g_bad_fmt
      $error("aclo_frame_tx: field does not fit a slot");
   end
   if (FRAME_LEN != 256) begin : g_bad_len
      $error("aclo_frame_tx: frame must be 256 bit times");
   end

   localparam int PCM_W = 2 * SAMPLE_W;

   logic [SLOT_IW-1:0]             slot_idx;
   logic [BIT_IW-1:0]              bit_idx;
   logic                           frame_last;
   logic                           sync_win;
   cmd_t                           cmd_in;
   cmd_t                           air_cmd;
   logic                           air_cmd_vld;
   logic [PCM_W-1:0]               air_pcm;
   logic                           air_pcm_vld;
   logic [NUM_WORDS-1:0][SLOT_W-1:0] words;
   logic                           cur_bit;

   aclo_bit_timer u_timer (
      .clk_i      (clk_i),
      .rst_n_i    (rst_n_i),
      .slot_o     (slot_idx),
      .bit_o      (bit_idx),
      .last_o     (frame_last),
      .sync_win_o (sync_win)
   );

   assign cmd_in = '{rd: cmd_read_i, addr: cmd_addr_i, data: cmd_wdata_i};

   aclo_req_stage #(.W(CMD_W)) u_cmd_stage (
      .clk_i      (clk_i),
      .rst_n_i    (rst_n_i),
      .valid_i    (cmd_valid_i),
      .data_i     (cmd_in),
      .ready_o    (cmd_ready_o),
      .load_i     (frame_last),
      .air_vld_o  (air_cmd_vld),
      .air_data_o (air_cmd)
   );

   aclo_req_stage #(.W(PCM_W)) u_pcm_stage (
      .clk_i      (clk_i),
      .rst_n_i    (rst_n_i),
      .valid_i    (pcm_valid_i),
      .data_i     ({pcm_left_i, pcm_right_i}),
      .ready_o    (pcm_ready_o),
      .load_i     (frame_last),
      .air_vld_o  (air_pcm_vld),
      .air_data_o (air_pcm)
   );

   aclo_slot_pack #(.SAMPLE_W(SAMPLE_W)) u_pack (
      .cmd_vld_i (air_cmd_vld),
      .cmd_i     (air_cmd),
      .pcm_vld_i (air_pcm_vld),
      .left_i    (air_pcm[PCM_W-1:SAMPLE_W]),
      .right_i   (air_pcm[SAMPLE_W-1:0]),
      .words_o   (words)
   );

   always_comb begin
      cur_bit = 1'b0;
      for (int s = 0; s < NUM_WORDS; s++) begin
         if (slot_idx == SLOT_IW'(s)) cur_bit = words[s][bit_idx];
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         sync_o  <= 1'b0;
         sdata_o <= 1'b0;
      end else begin
         sync_o  <= sync_win;
         sdata_o <= cur_bit;
      end
   end

   p_sync_rise_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      frame_last |=> $rose(sync_o));

   p_first_bit_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $rose(sync_o) |=> (sdata_o == $past(air_cmd_vld || air_pcm_vld)));

   p_tag_rsvd_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      ((slot_idx == SLOT_IW'(S_TAG)) && (bit_idx < BIT_IW'(TAG_RIGHT))) |=> !sdata_o);

   p_rd_slot2_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      ((slot_idx == SLOT_IW'(S_CMDD)) && !(air_cmd_vld && !air_cmd.rd)) |=> !sdata_o);

   p_reserved_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (slot_idx > SLOT_IW'(S_RIGHT)) |=> !sdata_o);

endmodule

// File: tb/aclo_frame_tx_tb_top.sv
`timescale 1ns/1ps
module aclo_frame_tx_tb_top;

   localparam int SW = 18;

   typedef struct packed {
      logic          c;
      logic          rd;
      logic [6:0]    a;
      logic [15:0]   d;
      logic          p;
      logic [SW-1:0] l;
      logic [SW-1:0] r;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0, cmd_read = 1'b0;
   logic [6:0]    cmd_addr = '0;
   logic [15:0]   cmd_wdata = '0;
   logic          pcm_valid = 1'b0;
   logic [SW-1:0] pcm_left = '0, pcm_right = '0;
   logic          cmd_ready, pcm_ready, sync, sdata;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit done     = 0;

   always #10 clk = ~clk;

   aclo_frame_tx #(.SAMPLE_W(SW)) dut_i (
      .clk_i(clk), .rst_n_i(rst_n),
      .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
      .cmd_read_i(cmd_read), .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata),
      .pcm_valid_i(pcm_valid), .pcm_ready_o(pcm_ready),
      .pcm_left_i(pcm_left), .pcm_right_i(pcm_right),
      .sync_o(sync), .sdata_o(sdata)
   );

   task automatic report();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 200000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=<200000", cycles);
         report();
      end
   end

   // frame monitor: k = bit time since the rise of sync
   int            k = -1;
   logic          psync = 1'b0;
   logic [255:0]  fb = '0, pub = '0;
   int            pub_cnt = 0, len_err = 0, sync_err = 0;

   always @(negedge clk) begin
      if (!rst_n) begin
         k = -1;
         psync = 1'b0;
      end else begin
         if (sync && !psync) begin
            if (k == 255) begin
               fb[0] = sdata;
               pub = fb;
               pub_cnt++;
            end else if (k != -1) len_err++;
            k = 0;
         end else if (k >= 0) begin
            k++;
            if (k <= 255) fb[256-k] = sdata;
            else len_err++;
            if (sync != (k < 16)) sync_err++;
         end
         psync = sync;
      end
   end

   task automatic wait_k(input int n);
      forever begin
         @(negedge clk); #1;
         if (k == n) break;
      end
   endtask

   int last_pub = 0;
   task automatic wait_pub();
      while (pub_cnt == last_pub) begin
         @(negedge clk); #1;
      end
      last_pub = pub_cnt;
   endtask

   function automatic logic [255:0] build(input item_t e);
      logic [15:0] tag;
      logic [19:0] s1, s2, s3, s4;
      tag = {e.c | e.p, e.c, e.c & ~e.rd, e.p, e.p, 11'b0};
      s1  = e.c ? {e.rd, e.a, 12'b0} : 20'b0;
      s2  = (e.c && !e.rd) ? {e.d, 4'b0} : 20'b0;
      s3  = e.p ? {e.l, {(20-SW){1'b0}}} : 20'b0;
      s4  = e.p ? {e.r, {(20-SW){1'b0}}} : 20'b0;
      return {tag, s1, s2, s3, s4, 160'b0};
   endfunction

   int sync_seen = 0, len_seen = 0;
   task automatic check_frame(input item_t e);
      logic [255:0] x;
      x = build(e);
      chk(sync_err == sync_seen, "R1 sync window", 64'(sync_err), 64'(sync_seen));
      chk(len_err == len_seen, "R1 frame length", 64'(len_err), 64'(len_seen));
      sync_seen = sync_err;
      len_seen  = len_err;
      chk(pub[255] == x[255], "R2 first bit after sync rise", 64'(pub[255]), 64'(x[255]));
      chk(pub[255:240] == x[255:240], "R3 tag", 64'(pub[255:240]), 64'(x[255:240]));
      chk(pub[239:220] == x[239:220], "R4 slot1", 64'(pub[239:220]), 64'(x[239:220]));
      chk(pub[219:200] == x[219:200], "R5 slot2", 64'(pub[219:200]), 64'(x[219:200]));
      chk(pub[199:160] == x[199:160], "R6 slots3-4", 64'(pub[199:160]), 64'(x[199:160]));
      chk(pub[159:0] == '0, "R7 slots5-12", 64'(pub[63:0] | pub[127:64] | 64'(pub[159:128])), 64'h0);
   endtask

   task automatic send(input item_t it, input bit junk);
      if (it.c) begin
         chk(cmd_ready, "R8 cmd ready before offer", 64'(cmd_ready), 64'h1);
         cmd_valid = 1'b1; cmd_read = it.rd; cmd_addr = it.a; cmd_wdata = it.d;
      end
      if (it.p) begin
         chk(pcm_ready, "R8 pcm ready before offer", 64'(pcm_ready), 64'h1);
         pcm_valid = 1'b1; pcm_left = it.l; pcm_right = it.r;
      end
      if (!it.c && !it.p) return;
      @(posedge clk);
      @(negedge clk); #1;
      cmd_valid = 1'b0;
      pcm_valid = 1'b0;
      if (it.c) chk(!cmd_ready, "R8 cmd ready drops", 64'(cmd_ready), 64'h0);
      if (it.p) chk(!pcm_ready, "R8 pcm ready drops", 64'(pcm_ready), 64'h0);
      if (junk) begin
         cmd_valid = 1'b1; cmd_read = ~it.rd; cmd_addr = ~it.a; cmd_wdata = ~it.d;
         pcm_valid = 1'b1; pcm_left = ~it.l; pcm_right = ~it.r;
         for (int j = 0; j < 5; j++) @(negedge clk);
         #1;
         cmd_valid = 1'b0;
         pcm_valid = 1'b0;
      end
   endtask

   item_t q0 = '0, q1 = '0, held = '0;

   // mode: 0 offer at bit time 100, 1 at 254, 2 at 255 (boundary edge),
   //       3 at 100 plus offers while not ready, 4 drain after mode 2
   task automatic step(input item_t it, input int mode);
      wait_pub();
      check_frame(q0);
      q0 = q1;
      if (mode == 4) begin
         chk(cmd_ready == !held.c, "R9 cmd ready low in gap frame", 64'(cmd_ready), 64'(!held.c));
         chk(pcm_ready == !held.p, "R9 pcm ready low in gap frame", 64'(pcm_ready), 64'(!held.p));
         q1 = held;
         return;
      end
      chk(cmd_ready && pcm_ready, "R8 ready after boundary", 64'({cmd_ready, pcm_ready}), 64'h3);
      wait_k(mode == 1 ? 254 : (mode == 2 ? 255 : 100));
      send(it, mode == 3);
      if (mode == 2) begin
         q1 = '0;
         held = it;
      end else begin
         q1 = it;
      end
   endtask

   initial begin
      item_t it;
      repeat (3) @(negedge clk);
      #1;
      chk(!sync && !sdata, "R10 outputs low in reset", 64'({sync, sdata}), 64'h0);
      chk(cmd_ready && pcm_ready, "R10 ready high in reset", 64'({cmd_ready, pcm_ready}), 64'h3);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(sync, "R10 first frame starts after reset", 64'(sync), 64'h1);

      for (int i = 0; i < 256; i++) begin
         int md;
         it = '0;
         it.c  = 1'b1;
         it.rd = i[7];
         it.a  = i[6:0];
         it.d  = 16'(i * 40503 + 7);
         it.p  = (i % 3) != 0;
         it.l  = SW'(i * 7919 ^ 32'h2A5A5);
         it.r  = SW'(~(i * 104729));
         md = (i % 9 == 4) ? 3 : ((i % 11 == 5) ? 1 : 0);
         if (md == 3) it.p = 1'b1;
         step(it, md);
      end

      step('0, 0);
      it = '0; it.p = 1'b1; it.l = 18'h3FFFF; it.r = 18'h00001;
      step(it, 2);
      step('0, 4);
      it = '0; it.c = 1'b1; it.rd = 1'b1; it.a = 7'h7F; it.d = 16'hFFFF;
      step(it, 2);
      step('0, 4);
      it = '0; it.c = 1'b1; it.a = 7'h55; it.d = 16'hA5C3; it.p = 1'b1;
      it.l = 18'h20001; it.r = 18'h1FFFE;
      step(it, 2);
      step('0, 4);
      it = '0; it.c = 1'b1; it.a = 7'h01; it.d = 16'h8001;
      step(it, 1);
      step('0, 0);
      step('0, 0);
      step('0, 0);
      report();
   end

endmodule